// File: doc/BRIEF.md
# Prescaled UART Baud Tick Generator

This block creates the timing enables that a UART transmitter and receiver share. An optional divide-by-4 stage slows the reference clock first. A 16-bit divisor then counts the prescaled enables. Each time the divisor count wraps, the block raises a one-cycle 16x oversampling tick. A second counter raises a 1x bit tick on every sixteenth 16x tick. Both ticks are enables in the reference clock domain, not separate clocks.

Software sets up the generator through a small write-only port. Two byte registers hold the low and high halves of the divisor. A mode register selects the prescaler. The divisor is therefore reference_frequency / (prescale × 16 × baud). Every accepted write restarts the prescaler, the divisor counter and the bit counter, so a new setting starts from a clean count. A divisor of zero stops all ticks. Reset leaves the divisor at zero, which keeps the generator quiet until software programs it.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset the divisor bytes and the prescale select are zero, and neither tick output is asserted until a non-zero divisor has been written.
- R2: A write to address 0 loads divisor bits 7:0, and a write to address 1 loads divisor bits 15:8. With the prescaler at divide-by-1 and divisor N (1 to 65535), tick16_o rises once every N clock cycles.
- R3: Bit 7 of a write to address 2 selects the prescaler. A 1 divides by 4, giving a tick16_o period of 4·N cycles. A 0 divides by 1. The other bits of that write are ignored.
- R4: While both divisor bytes are zero, neither tick16_o nor tick1_o is asserted.
- R5: tick16_o is a single-cycle pulse. With divisor 1 and divide-by-1 it is asserted on every clock cycle.
- R6: A write to address 0, 1 or 2 restarts the count. If the clock edge that takes the write is cycle W, the first tick16_o appears at cycle W+1+P·N, where P is the prescale (1 or 4). The cycle after the write edge carries no tick16_o.
- R7: tick1_o is a single-cycle pulse. It is asserted one cycle after every 16th tick16_o, counted from the last restart. The first one appears at cycle W+2+16·P·N.
- R8: A write to address 3, or a cycle with wr_en low, changes no register and does not restart the count. The tick16_o phase runs on unbroken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 divisor low, 1 divisor high, 2 mode |
| wr_data | input | 8 | Write data |
| tick16_o | output | 1 | 16x oversampling enable pulse |
| tick1_o | output | 1 | 1x bit-rate enable pulse |

## Verification
The bench measures the exact cycle of the first tick after each write and the spacing of the ticks that follow. An off-by-one in the wrap compare, a counter that is not restarted, or a prescaler stage that is not cleared would all shift these cycles. Divisor 1 at divide-by-1 checks that the tick is held high on every cycle; a design that forced a low cycle between pulses would halve the rate there. A zero divisor must stay silent; a design that treated zero as 65536 would emit ticks. A write to the unused address must leave the tick phase untouched; a design that decoded it as a divisor or restart write would shift the phase or stop the ticks.

// File: rtl/baud_pkg.sv
package baud_pkg;

    // Default geometry of the generator
    localparam int BYTE_W_DEF    = 8;
    localparam int NUM_BYTES_DEF = 2;
    localparam int PRE_W         = 2;   // counter width of the divide-by-4 stage
    localparam int BIT_OVERSAMP  = 16;  // 16x ticks per bit tick
    localparam int BIT_CNT_W     = $clog2(BIT_OVERSAMP);

    typedef enum logic [1:0] {
        PRE_DIV1 = 2'd0,
        PRE_DIV4 = 2'd1
    } pre_mode_e;

    typedef struct packed {
        logic [PRE_W-1:0] cnt;
    } pre_state_t;

    typedef struct packed {
        logic [BIT_CNT_W-1:0] cnt;
        logic                 tick;
    } bit_state_t;

endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
    import baud_pkg::*;
#(
    parameter int BYTE_W    = BYTE_W_DEF,
    parameter int NUM_BYTES = NUM_BYTES_DEF,
    parameter int ADDR_W    = 2,
    parameter int MODE_BIT  = 7
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [ADDR_W-1:0]           wr_addr_i,
    input  logic [BYTE_W-1:0]           wr_data_i,
    output logic [BYTE_W*NUM_BYTES-1:0] divisor_o,
    output pre_mode_e                   pre_mode_o,
    output logic                        reload_o
);

    localparam int DIV_W = BYTE_W * NUM_BYTES;
    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(NUM_BYTES);

    typedef struct packed {
        logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes;
        pre_mode_e                        mode;
        logic                             reload;
    } cfg_state_t;

    cfg_state_t state_d, state_q;
    logic [NUM_BYTES-1:0] byte_hit;

    // One address decode per divisor byte
    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte_dec
        assign byte_hit[g] = wr_en_i && (wr_addr_i == ADDR_W'(g));
    end

    always_comb begin
        state_d        = state_q;
        state_d.reload = 1'b0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (byte_hit[i]) begin
                state_d.bytes[i] = wr_data_i;
                state_d.reload   = 1'b1;
            end
        end
        if (wr_en_i && (wr_addr_i == MODE_ADDR)) begin
            state_d.mode   = wr_data_i[MODE_BIT] ? PRE_DIV4 : PRE_DIV1;
            state_d.reload = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{bytes: '0, mode: PRE_DIV1, reload: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign divisor_o  = DIV_W'(state_q.bytes);
    assign pre_mode_o = state_q.mode;
    assign reload_o   = state_q.reload;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> (!reload_o && $stable(divisor_o) && $stable(pre_mode_o))); // R8

    AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i > MODE_ADDR)) |=> (!reload_o && $stable(divisor_o))); // R8

    AST_WRITE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_addr_i <= MODE_ADDR)) |=> reload_o); // R6

endmodule

// File: rtl/baud_prescaler.sv
module baud_prescaler
    import baud_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  pre_mode_e pre_mode_i,
    input  logic      reload_i,
    output logic      pre_en_o
);

    localparam logic [PRE_W-1:0] PRE_LAST = '1;

    pre_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (reload_i || (pre_mode_i == PRE_DIV1)) begin
            state_d.cnt = '0;
        end else begin
            state_d.cnt = state_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cnt: '0};
        end else begin
            state_q <= state_d;
        end
    end

    assign pre_en_o = (pre_mode_i == PRE_DIV1) || (state_q.cnt == PRE_LAST);

    AST_PRE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((pre_mode_i == PRE_DIV4) && pre_en_o && !reload_i)
            |=> (!pre_en_o || (pre_mode_i == PRE_DIV1))); // R3

    AST_PRE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_mode_i == PRE_DIV1) |-> pre_en_o); // R3

endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divisor_i,
    input  logic             pre_en_i,
    input  logic             reload_i,
    output logic             tick16_o
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tick;
    } div_state_t;

    div_state_t       state_d, state_q;
    logic             div_zero;
    logic [DIV_W-1:0] wrap_val;

    assign div_zero = (divisor_i == '0);
    assign wrap_val = divisor_i - 1'b1;

    always_comb begin
        state_d      = state_q;
        state_d.tick = 1'b0;
        if (reload_i || div_zero) begin
            state_d.cnt = '0;
        end else if (pre_en_i) begin
            if (state_q.cnt >= wrap_val) begin
                state_d.cnt  = '0;
                state_d.tick = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cnt: '0, tick: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign tick16_o = state_q.tick;

    AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        div_zero |=> !tick16_o); // R4

    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !tick16_o); // R6

    AST_NO_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !pre_en_i |=> !tick16_o); // R3

endmodule

// File: rtl/baud_bit_divider.sv
module baud_bit_divider
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick16_i,
    input  logic reload_i,
    output logic tick1_o
);

    localparam logic [BIT_CNT_W-1:0] BIT_LAST = BIT_CNT_W'(BIT_OVERSAMP - 1);

    bit_state_t state_d, state_q;

    always_comb begin
        state_d      = state_q;
        state_d.tick = 1'b0;
        if (reload_i) begin
            state_d.cnt = '0;
        end else if (tick16_i) begin
            if (state_q.cnt == BIT_LAST) begin
                state_d.cnt  = '0;
                state_d.tick = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cnt: '0, tick: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign tick1_o = state_q.tick;

    AST_BIT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        tick1_o |-> $past(tick16_i)); // R7

    AST_BIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick1_o |=> !tick1_o); // R7

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
    import baud_pkg::*;
#(
    parameter int BYTE_W    = BYTE_W_DEF,
    parameter int NUM_BYTES = NUM_BYTES_DEF,
    parameter int ADDR_W    = 2,
    parameter int MODE_BIT  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic              tick16_o,
    output logic              tick1_o
);

    localparam int DIV_W = BYTE_W * NUM_BYTES;

    logic [DIV_W-1:0] divisor;
    pre_mode_e        pre_mode;
    logic             reload;
    logic             pre_en;

    baud_cfg_regs #(
        .BYTE_W   (BYTE_W),
        .NUM_BYTES(NUM_BYTES),
        .ADDR_W   (ADDR_W),
        .MODE_BIT (MODE_BIT)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .divisor_o (divisor),
        .pre_mode_o(pre_mode),
        .reload_o  (reload)
    );

    baud_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .pre_mode_i(pre_mode),
        .reload_i  (reload),
        .pre_en_o  (pre_en)
    );

    baud_div_counter #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .divisor_i(divisor),
        .pre_en_i (pre_en),
        .reload_i (reload),
        .tick16_o (tick16_o)
    );

    baud_bit_divider u_bit (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16_i(tick16_o),
        .reload_i(reload),
        .tick1_o (tick1_o)
    );

    AST_BIT_NEEDS_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        tick1_o |-> $past(divisor != '0)); // R4

endmodule

// File: tb/tb_baud_tick_gen.sv
`timescale 1ns/1ps
module tb_baud_tick_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       tick16_o;
    logic       tick1_o;

    int cyc = 0;
    int n_tests = 0;
    int n_fail = 0;
    int wr_cyc = 0;
    // Observation results
    int first16, second16, cnt16, consec16;
    int first1, second1, cnt1;

    baud_tick_gen dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick16_o(tick16_o),
        .tick1_o (tick1_o)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        wr_cyc = cyc;
    endtask

    task automatic observe(input int len);
        bit prev = 1'b0;
        first16 = -1; second16 = -1; cnt16 = 0; consec16 = 0;
        first1 = -1; second1 = -1; cnt1 = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (tick16_o) begin
                if (cnt16 == 0) first16 = cyc;
                else if (cnt16 == 1) second16 = cyc;
                cnt16++;
                if (prev) consec16++;
            end
            prev = tick16_o;
            if (tick1_o) begin
                if (cnt1 == 0) first1 = cyc;
                else if (cnt1 == 1) second1 = cyc;
                cnt1++;
            end
        end
    endtask

    task automatic program_rate(input bit div4, input int n);
        reg_write(2'd2, div4 ? 8'h80 : 8'h7F);
        reg_write(2'd0, 8'(n));
        reg_write(2'd1, 8'(n >> 8));
    endtask

    task automatic t_reset();
        observe(60);
        chk(cnt16 == 0, "R1 no tick16 after reset", cnt16, 0);
        chk(cnt1 == 0, "R1 no tick1 after reset", cnt1, 0);
    endtask

    task automatic t_rate(input bit div4, input int n, input string req);
        int pn = (div4 ? 4 : 1) * n;
        program_rate(div4, n);
        observe(2 * pn + 4);
        chk(first16 == wr_cyc + 1 + pn, {req, " R6 first tick16"}, first16 - wr_cyc, 1 + pn);
        chk(second16 - first16 == pn, {req, " period"}, second16 - first16, pn);
        if (pn > 1)
            chk(consec16 == 0, "R5 single-cycle tick16", consec16, 0);
        else
            chk(consec16 == cnt16 - 1, "R5 tick16 every cycle", consec16, cnt16 - 1);
    endtask

    task automatic t_zero();
        program_rate(1'b0, 5);
        observe(12);
        reg_write(2'd0, 8'h00);
        observe(80);
        chk(cnt16 == 0, "R4 zero divisor tick16", cnt16, 0);
        chk(cnt1 == 0, "R4 zero divisor tick1", cnt1, 0);
    endtask

    task automatic t_bit(input bit div4, input int n);
        int pn = (div4 ? 4 : 1) * n;
        program_rate(div4, n);
        observe(32 * pn + 8);
        chk(first1 == wr_cyc + 2 + 16 * pn, "R7 first tick1", first1 - wr_cyc, 2 + 16 * pn);
        chk(second1 - first1 == 16 * pn, "R7 tick1 period", second1 - first1, 16 * pn);
    endtask

    task automatic t_ignore();
        int base;
        program_rate(1'b0, 4);
        base = wr_cyc + 5;
        observe(20);
        reg_write(2'd3, 8'h00);
        observe(24);
        chk(cnt16 == 6, "R8 ticks continue after unmapped write", cnt16, 6);
        chk(((first16 - base) % 4) == 0, "R8 phase kept", (first16 - base) % 4, 0);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 2'd0; wr_data = 8'h00;
        observe(12);
        chk(cnt16 == 3, "R8 idle bus keeps rate", cnt16, 3);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(tick16_o == 1'b0, "R1 tick16 low in reset", int'(tick16_o), 0);
        chk(tick1_o == 1'b0, "R1 tick1 low in reset", int'(tick1_o), 0);
        rst_n = 1'b1;
        t_reset();
        t_rate(1'b0, 5, "R2");
        t_rate(1'b0, 259, "R2 high byte");
        t_rate(1'b1, 3, "R3 div4");
        t_rate(1'b0, 1, "R5");
        t_rate(1'b1, 1, "R3 div4 n1");
        t_zero();
        t_bit(1'b0, 2);
        t_bit(1'b1, 1);
        t_ignore();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule